// File: doc/BRIEF.md
# Range-Protected Byte Store Write Gate

This block holds a 512-byte store and a small control register. One write port reaches both. A write to the store goes through only when its address lies outside the window picked by a 3-bit protect code. A write aimed inside the window is dropped without any error on the bus. The only sign of the drop is a one-cycle reject pulse for whoever is watching.

The protect code has eight settings, and they do not scale smoothly:

- Some settings guard the top of the store: a quarter, a half, or all of it.
- Others guard the bottom in power-of-two counts of 64-byte pages.

Reads are never blocked. The read port returns either a stored byte or the control register contents, one cycle after the address is presented.

Top module: `bpWriteGate`

## Requirements
- R1: After reset the protect code is 000, `wrReject` is 0, every stored byte is 0x00, and `rdData` is 0x00.
- R2: With code 000 a write to any address from 0x000 to 0x1FF is stored.
- R3: With code 001 writes to 0x180–0x1FF are refused and lower addresses are stored. With code 010 writes to 0x100–0x1FF are refused and lower addresses are stored.
- R4: With code 011 or code 111 every store write is refused.
- R5: Codes 100, 101 and 110 refuse writes to 0x000–0x03F, 0x000–0x07F and 0x000–0x0FF respectively, and store writes above those ranges.
- R6: A refused write leaves the addressed byte unchanged.
- R7: `wrReject` is 1 for exactly the one cycle after the clock edge that sampled a refused store write. It stays 0 after an accepted write and after a control write.
- R8: A write with `ctrlSel`=1 loads `wrData[2:0]` as the new protect code, regardless of the current code. A store write in the very next cycle is judged by the new code. Reading with `rdCtrl`=1 returns the code in bits [2:0] and zeros in bits [7:3].
- R9: With `rdCtrl`=0, `rdData` shows the byte at `rdAddr` one clock edge after the address is sampled, whatever the protect code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| ctrlSel | input | 1 | 1: the write targets the control register; 0: the write targets the store |
| addr | input | 9 | Store write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 9 | Store read address |
| rdCtrl | input | 1 | 1: read the control register instead of the store |
| rdData | output | 8 | Registered read data |
| wrReject | output | 1 | One-cycle pulse for a refused store write |

## Verification
Each of the eight codes is tried with writes at both edges of every range boundary (0x03F/0x040, 0x07F/0x080, 0x0FF/0x100, 0x17F/0x180), plus 0x000 and 0x1FF. This separates an off-by-one boundary from a swapped upper-fraction or lower-page decode. Every write is followed by a readback, so a refused write that still lands is caught, not only a missing pulse. A control write followed at once by a store write checks that the new code applies with no stale cycle. Writes and reads under the fully locking codes confirm that reads are never blocked.

// File: rtl/bpGatePkg.sv
package bpGatePkg;
  typedef struct packed {
    logic memWe;   // commit the byte into the store
    logic ctrlWe;  // load the protect code
    logic reject;  // store write refused
  } bpStrobe_t;
endpackage

// File: rtl/bpCtrl.sv
module bpCtrl
  import bpGatePkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PROT_W = 3,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              ctrlSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PROT_W-1:0] codeIn,
  output logic [PROT_W-1:0] protCode,
  output bpStrobe_t         strb
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] UPPER_QTR = (ADDR_W+1)'(DEPTH * 3 / 4);
  localparam logic [ADDR_W:0] UPPER_HALF = (ADDR_W+1)'(DEPTH / 2);
  localparam logic [ADDR_W:0] PG1 = (ADDR_W+1)'(PAGE_BYTES);
  localparam logic [ADDR_W:0] PG2 = (ADDR_W+1)'(PAGE_BYTES * 2);
  localparam logic [ADDR_W:0] PG4 = (ADDR_W+1)'(PAGE_BYTES * 4);

  logic [ADDR_W:0] addrX;
  logic inWindow;

  assign addrX = {1'b0, addr};

  // Irregular decode: upper fractions for the low codes, first pages for the high codes
  always_comb begin
    case (protCode)
      3'd0:    inWindow = 1'b0;
      3'd1:    inWindow = addrX >= UPPER_QTR;
      3'd2:    inWindow = addrX >= UPPER_HALF;
      3'd4:    inWindow = addrX < PG1;
      3'd5:    inWindow = addrX < PG2;
      3'd6:    inWindow = addrX < PG4;
      default: inWindow = 1'b1;  // 3 and 7 lock the whole store
    endcase
  end

  always_comb begin
    strb.ctrlWe = wrEn && ctrlSel;
    strb.memWe  = wrEn && !ctrlSel && !inWindow;
    strb.reject = wrEn && !ctrlSel && inWindow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) protCode <= '0;
    else if (strb.ctrlWe) protCode <= codeIn;
  end

  p_code_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWe |=> protCode == $past(codeIn));
  p_open_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (protCode == 3'd0 && wrEn && !ctrlSel) |-> strb.memWe);
  p_full_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((protCode == 3'd3 || protCode == 3'd7) && wrEn && !ctrlSel) |-> strb.reject);
  p_top_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((protCode == 3'd1 || protCode == 3'd2) && wrEn && !ctrlSel && addr == '1) |-> strb.reject);
endmodule

// File: rtl/bpDatapath.sv
module bpDatapath
  import bpGatePkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdCtrl,
  input  logic [PROT_W-1:0] protCode,
  output logic [DATA_W-1:0] rdData,
  output logic              wrReject
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.memWe) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      wrReject <= 1'b0;
    end else begin
      rdData   <= rdCtrl ? {{(DATA_W-PROT_W){1'b0}}, protCode} : mem[rdAddr];
      wrReject <= strb.reject;
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWe |=> mem[$past(wrAddr)] == $past(wrData));
  p_refused_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> mem[$past(wrAddr)] == $past(mem[wrAddr]));
  p_pulse_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> $past(strb.reject));
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.memWe, strb.reject, strb.ctrlWe}));
endmodule

// File: rtl/bpWriteGate.sv
module bpWriteGate
  import bpGatePkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int PROT_W = 3,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              ctrlSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdCtrl,
  output logic [DATA_W-1:0] rdData,
  output logic              wrReject
);
  bpStrobe_t strb;
  logic [PROT_W-1:0] protCode;

  bpCtrl #(.ADDR_W(ADDR_W), .PROT_W(PROT_W), .PAGE_BYTES(PAGE_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlSel(ctrlSel), .addr(addr),
    .codeIn(wrData[PROT_W-1:0]), .protCode(protCode), .strb(strb)
  );

  bpDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(addr), .wrData(wrData),
    .rdAddr(rdAddr), .rdCtrl(rdCtrl), .protCode(protCode),
    .rdData(rdData), .wrReject(wrReject)
  );
endmodule

// File: tb/sim_bpWriteGate.sv
module sim_bpWriteGate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, ctrlSel = 1'b0, rdCtrl = 1'b0;
  logic [8:0] addr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic wrReject;

  int vecs = 0, miss = 0;
  bit done = 0;
  logic [7:0] model [512];
  logic [2:0] curCode = 3'd0;

  always #2 clk = ~clk;  // 250 MHz

  bpWriteGate u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlSel(ctrlSel), .addr(addr),
    .wrData(wrData), .rdAddr(rdAddr), .rdCtrl(rdCtrl), .rdData(rdData), .wrReject(wrReject));

  function automatic bit guarded(logic [2:0] c, logic [8:0] a);
    case (c)
      3'd0: return 1'b0;
      3'd1: return a >= 9'h180;
      3'd2: return a >= 9'h100;
      3'd4: return a <= 9'h03F;
      3'd5: return a <= 9'h07F;
      3'd6: return a <= 9'h0FF;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tagFor(logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd7: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic setCode(logic [2:0] c);
    @(negedge clk);
    wrEn = 1; ctrlSel = 1; wrData = {5'b10101, c};
    @(negedge clk);
    wrEn = 0; ctrlSel = 0;
    curCode = c;
    check("R7 ctrl write no pulse", {8'b0, wrReject}, 9'd0);
  endtask

  task automatic storeWrite(logic [8:0] a, logic [7:0] d);
    bit g;
    g = guarded(curCode, a);
    @(negedge clk);
    wrEn = 1; ctrlSel = 0; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    check("R7 reject pulse", {8'b0, wrReject}, {8'b0, g});
    if (!g) model[a] = d;
    @(negedge clk);
    check("R7 pulse one cycle", {8'b0, wrReject}, 9'd0);
  endtask

  task automatic readByte(logic [8:0] a, string req);
    @(negedge clk);
    rdAddr = a; rdCtrl = 0;
    @(negedge clk);
    check(req, {1'b0, rdData}, {1'b0, model[a]});
  endtask

  task automatic readCode(string req);
    @(negedge clk);
    rdCtrl = 1;
    @(negedge clk);
    rdCtrl = 0;
    check(req, {1'b0, rdData}, {6'b0, curCode});
  endtask

  task automatic testReset();
    check("R1 wrReject", {8'b0, wrReject}, 9'd0);
    check("R1 rdData", {1'b0, rdData}, 9'd0);
    readCode("R1 code default");
    readByte(9'h000, "R1 byte 000");
    readByte(9'h1FF, "R1 byte 1FF");
  endtask

  task automatic testCode(logic [2:0] c);
    logic [8:0] pts [10] = '{9'h000, 9'h03F, 9'h040, 9'h07F, 9'h080,
                             9'h0FF, 9'h100, 9'h17F, 9'h180, 9'h1FF};
    setCode(c);
    readCode("R8 readback");
    foreach (pts[i]) begin
      storeWrite(pts[i], {c, 5'(i)} ^ 8'h5A);
      readByte(pts[i], guarded(c, pts[i]) ? "R6 refused byte kept" : tagFor(c));
    end
    readByte(9'h0AA, "R9 read under any code");
  endtask

  // Control write immediately followed by store write: new code must apply
  task automatic testBackToBack();
    @(negedge clk);
    wrEn = 1; ctrlSel = 1; wrData = 8'h03;
    @(negedge clk);
    ctrlSel = 0; addr = 9'h010; wrData = 8'hC3;
    curCode = 3'd3;
    check("R8 ctrl no pulse", {8'b0, wrReject}, 9'd0);
    @(negedge clk);
    wrEn = 0;
    check("R8 new code applied", {8'b0, wrReject}, 9'd1);
    readByte(9'h010, "R8 byte kept under new code");
    setCode(3'd0);
    storeWrite(9'h010, 8'h3C);
    readByte(9'h010, "R2 reopened");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    for (int c = 0; c < 8; c++) testCode(3'(c));
    testBackToBack();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule